// File: doc/BRIEF.md
# Compact 16-bit Instruction Executor

This block executes the two-byte instruction forms of a 32-bit RISC core against a sixteen-entry register file of 32-bit words. One instruction word arrives with a valid strobe. The block splits it into fields, forms any immediate, and computes the result. It then writes the register file and reports that write on a writeback port. Loads and stores go out as a memory request with a valid/ready handshake. A return instruction produces a one-cycle jump pulse with its target for the fetch unit. Encodings the block does not carry out are flagged on two pulse outputs: one for reserved or illegal codes, one for forms that belong to other units.

A separate combinational output tells an instruction aligner whether a first byte starts a two-byte or a three-byte instruction. The aligner gives only the low nibble of that byte, because nothing else in the byte matters.

Instruction word layout, with the first byte in memory as the low byte: major opcode in bits [3:0], field t in [7:4], field s in [11:8], field r in [15:12].

Top module: `cinsn_exec`

## Requirements
- R1: `len_two` is 1 exactly when the 4-bit value on `first_lo` is 8 or more. Otherwise it is 0, which marks a three-byte instruction.
- R2: Opcode 8 (load) and opcode 9 (store) raise `mem_req_valid` one cycle after they are accepted. The address is register s plus (r << 2). `mem_req_write` is 1 for opcode 9 and 0 for opcode 8. For a store, `mem_req_wdata` is register t, and a store never produces a writeback.
- R3: From the accept of a load until its response, `insn_ready` stays low. Register t is written only when `mem_rsp_valid` arrives, and the writeback shows the returned data one cycle later.
- R4: Opcode 10 writes register s + register t into register r.
- R5: Opcode 11 writes register s + imm into register r. Here imm = t, except that t = 0 gives imm = -1.
- R6: Opcode 12 with t < 8 writes into register s the value {t[2:0], r}. When t[2] and t[1] are both 1, bits 31..7 are all ones. Otherwise they are zero.
- R7: Opcode 13 with r = 0 copies register s into register t.
- R8: Opcode 13 with r = 15 and t = 0 raises `jump_valid` for exactly one cycle, starting the cycle after accept. In that cycle `jump_target` equals register 0.
- R9: Opcode 13 with r = 15 and t = 3 is a no-op: it raises no writeback, jump, exception or unsupported pulse.
- R10: These encodings raise `exc_valid` for one cycle and write no register:
  - opcode 13 with r = 15 and t = 6, or t in {4, 5, 7..15};
  - opcode 13 with r in 1..14;
  - opcodes 14 and 15;
  - any opcode below 8.
- R11: Opcode 12 with t >= 8, and opcode 13 with r = 15 and t = 1 or t = 2, raise `unsup_valid` for one cycle and change no register.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address and data stay unchanged.
- R13: After reset, `wb_valid`, `jump_valid`, `exc_valid`, `unsup_valid` and `mem_req_valid` are 0 and `insn_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| insn_valid | input | 1 | Instruction word present |
| insn_word | input | 16 | Instruction word, first byte in bits [7:0] |
| insn_ready | output | 1 | Block can accept an instruction this cycle |
| first_lo | input | 4 | Low nibble of a first instruction byte |
| len_two | output | 1 | 1 when that byte starts a two-byte instruction |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 store, 0 load |
| mem_req_addr | output | XLEN | Byte address |
| mem_req_wdata | output | XLEN | Store data |
| mem_rsp_valid | input | 1 | Load data present |
| mem_rsp_rdata | input | XLEN | Load data |
| wb_valid | output | 1 | A register was written in the previous cycle |
| wb_idx | output | 4 | Index of that register |
| wb_data | output | XLEN | Value written |
| jump_valid | output | 1 | Return taken |
| jump_target | output | XLEN | Return address |
| exc_valid | output | 1 | Reserved or illegal encoding seen |
| unsup_valid | output | 1 | Encoding handled outside this block |

## Verification
Register values can only be seen through the ports. A bad register state therefore shows up in the first later instruction that reads that register: in the writeback data of an arithmetic or move, in the data of a store, or in the target of a return, one cycle after that instruction is accepted. A stuck load/store sequencer shows directly. Either `insn_ready` stays low, or a writeback appears in a cycle where no response was given. The bench stores registers back out after each flagged encoding, so a write that should have been suppressed shows as wrong store data.

// File: rtl/cinsn_pkg.sv
package cinsn_pkg;
  localparam int FW = 4;

  typedef enum logic [3:0] {
    K_NONE, K_LOAD, K_STORE, K_ADD, K_ADDI, K_MOVI, K_MOV,
    K_RET, K_NOP, K_EXC, K_UNSUP
  } kind_e;

  typedef enum logic [1:0] { LS_IDLE, LS_REQ, LS_WAIT } ls_e;

  // Two-byte forms are selected by the top bit of the major opcode
  function automatic logic is_short(input logic [FW-1:0] op);
    return op[FW-1];
  endfunction
endpackage

// File: rtl/cinsn_decode.sv
module cinsn_decode
  import cinsn_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [4*FW-1:0] word,
  output kind_e           kind,
  output logic [FW-1:0]   f_r,
  output logic [FW-1:0]   f_s,
  output logic [FW-1:0]   f_t,
  output logic [XLEN-1:0] imm
);
  localparam int MVW = 7;
  logic [FW-1:0] op;

  always_comb begin
    op   = word[FW-1:0];
    f_t  = word[2*FW-1:FW];
    f_s  = word[3*FW-1:2*FW];
    f_r  = word[4*FW-1:3*FW];
    imm  = '0;
    kind = K_EXC;
    unique case (op)
      4'd8:  kind = K_LOAD;
      4'd9:  kind = K_STORE;
      4'd10: kind = K_ADD;
      4'd11: begin
        kind = K_ADDI;
        imm  = (f_t == '0) ? '1 : XLEN'(f_t);
      end
      4'd12: begin
        if (!f_t[3]) begin
          kind = K_MOVI;
          imm  = {{(XLEN-MVW){f_t[2] & f_t[1]}}, f_t[2:0], f_r};
        end else begin
          kind = K_UNSUP;
        end
      end
      4'd13: begin
        if (f_r == 4'd0) begin
          kind = K_MOV;
        end else if (f_r == 4'd15) begin
          unique case (f_t)
            4'd0:       kind = K_RET;
            4'd1, 4'd2: kind = K_UNSUP;
            4'd3:       kind = K_NOP;
            default:    kind = K_EXC;
          endcase
        end
      end
      default: kind = K_EXC;
    endcase
  end
endmodule

// File: rtl/cinsn_regfile.sv
module cinsn_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  parameter int NRD  = 3
) (
  input  logic                                clk,
  input  logic                                we,
  input  logic [$clog2(NREG)-1:0]             widx,
  input  logic [XLEN-1:0]                     wdata,
  input  logic [NRD-1:0][$clog2(NREG)-1:0]    rd_idx,
  output logic [NRD-1:0][XLEN-1:0]            rd_data
);
  logic [XLEN-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we && widx == i) q[i] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = q[rd_idx[p]];
  end
endmodule

// File: rtl/cinsn_lsu.sv
module cinsn_lsu
  import cinsn_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_ld,
  input  logic            start_st,
  input  logic [XLEN-1:0] addr,
  input  logic [XLEN-1:0] sdata,
  input  logic [FW-1:0]   tidx,
  output logic            req_valid,
  input  logic            req_ready,
  output logic            req_write,
  output logic [XLEN-1:0] req_addr,
  output logic [XLEN-1:0] req_wdata,
  input  logic            rsp_valid,
  input  logic [XLEN-1:0] rsp_data,
  output logic            busy,
  output logic            we,
  output logic [FW-1:0]   widx,
  output logic [XLEN-1:0] wdata
);
  ls_e           st_q, st_n;
  logic          wr_q;
  logic [FW-1:0] tix_q;
  logic          cap;

  always_comb begin
    st_n = st_q;
    we   = 1'b0;
    cap  = 1'b0;
    unique case (st_q)
      LS_IDLE: if (start_ld || start_st) begin
        st_n = LS_REQ;
        cap  = 1'b1;
      end
      LS_REQ:  if (req_ready) st_n = wr_q ? LS_IDLE : LS_WAIT;
      LS_WAIT: if (rsp_valid) begin
        st_n = LS_IDLE;
        we   = 1'b1;
      end
      default: st_n = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LS_IDLE;
    else        st_q <= st_n;
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      wr_q      <= start_st;
      tix_q     <= tidx;
      req_addr  <= addr;
      req_wdata <= sdata;
    end
  end

  assign req_valid = (st_q == LS_REQ);
  assign req_write = wr_q;
  assign busy      = (st_q != LS_IDLE);
  assign widx      = tix_q;
  assign wdata     = rsp_data;

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_wdata)));
endmodule

// File: rtl/cinsn_exec.sv
module cinsn_exec
  import cinsn_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  input  logic [15:0]     insn_word,
  output logic            insn_ready,
  input  logic [3:0]      first_lo,
  output logic            len_two,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [XLEN-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_rdata,
  output logic            wb_valid,
  output logic [3:0]      wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic            jump_valid,
  output logic [XLEN-1:0] jump_target,
  output logic            exc_valid,
  output logic            unsup_valid
);
  localparam int NRD = 3;

  logic [1:0]      rs_q;
  logic            rst_i;
  kind_e           kind;
  logic [FW-1:0]   f_r, f_s, f_t;
  logic [XLEN-1:0] imm;
  logic [NRD-1:0][FW-1:0]   rd_idx;
  logic [NRD-1:0][XLEN-1:0] rd_data;
  logic [XLEN-1:0] v_s, v_t, v_0;
  logic            acc, busy;
  logic            l_we;
  logic [FW-1:0]   l_idx;
  logic [XLEN-1:0] l_data;
  logic            we_n, jmp_n, exc_n, uns_n;
  logic [FW-1:0]   widx_n;
  logic [XLEN-1:0] wdata_n;

  // reset: asynchronous assert, two-flop synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign len_two = is_short(first_lo);

  cinsn_decode #(.XLEN(XLEN)) u_dec (
    .word(insn_word), .kind(kind), .f_r(f_r), .f_s(f_s), .f_t(f_t), .imm(imm)
  );

  assign rd_idx = {4'd0, f_t, f_s};
  assign v_s = rd_data[0];
  assign v_t = rd_data[1];
  assign v_0 = rd_data[2];

  cinsn_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk(clk), .we(we_n), .widx(widx_n), .wdata(wdata_n),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  assign insn_ready = rst_i && !busy;
  assign acc        = insn_valid && insn_ready;

  cinsn_lsu #(.XLEN(XLEN)) u_lsu (
    .clk(clk), .rst_n(rst_i),
    .start_ld(acc && kind == K_LOAD), .start_st(acc && kind == K_STORE),
    .addr(v_s + {{(XLEN-FW-2){1'b0}}, f_r, 2'b00}), .sdata(v_t), .tidx(f_t),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_write(mem_req_write),
    .req_addr(mem_req_addr), .req_wdata(mem_req_wdata),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_rdata),
    .busy(busy), .we(l_we), .widx(l_idx), .wdata(l_data)
  );

  always_comb begin
    we_n    = 1'b0;
    widx_n  = f_r;
    wdata_n = v_s + v_t;
    jmp_n   = 1'b0;
    exc_n   = 1'b0;
    uns_n   = 1'b0;
    if (l_we) begin
      we_n    = 1'b1;
      widx_n  = l_idx;
      wdata_n = l_data;
    end else if (acc) begin
      unique case (kind)
        K_ADD:   we_n = 1'b1;
        K_ADDI:  begin we_n = 1'b1; wdata_n = v_s + imm; end
        K_MOVI:  begin we_n = 1'b1; widx_n = f_s; wdata_n = imm; end
        K_MOV:   begin we_n = 1'b1; widx_n = f_t; wdata_n = v_s; end
        K_RET:   jmp_n = 1'b1;
        K_EXC:   exc_n = 1'b1;
        K_UNSUP: uns_n = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      wb_valid    <= 1'b0;
      jump_valid  <= 1'b0;
      exc_valid   <= 1'b0;
      unsup_valid <= 1'b0;
    end else begin
      wb_valid    <= we_n;
      jump_valid  <= jmp_n;
      exc_valid   <= exc_n;
      unsup_valid <= uns_n;
    end
  end

  always_ff @(posedge clk) begin
    if (we_n) begin
      wb_idx  <= widx_n;
      wb_data <= wdata_n;
    end
    if (jmp_n) jump_target <= v_0;
  end

  // R10 R11 R8: at most one kind of result per cycle
  outs_excl_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({wb_valid, jump_valid, exc_valid, unsup_valid}));

  // R3
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_i)
    mem_req_valid |-> !insn_ready);

  // R2
  st_nowb_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_req_valid && mem_req_ready && mem_req_write) |=> !wb_valid);

  // R3
  ld_rsp_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_req_valid && !mem_req_write) |=> !wb_valid);
endmodule

// File: tb/cinsn_exec_tb.sv
module cinsn_exec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            insn_valid;
  logic [15:0]     insn_word;
  logic            insn_ready;
  logic [3:0]      first_lo;
  logic            len_two;
  logic            mem_req_valid, mem_req_ready, mem_req_write;
  logic [XLEN-1:0] mem_req_addr, mem_req_wdata;
  logic            mem_rsp_valid;
  logic [XLEN-1:0] mem_rsp_rdata;
  logic            wb_valid;
  logic [3:0]      wb_idx;
  logic [XLEN-1:0] wb_data;
  logic            jump_valid;
  logic [XLEN-1:0] jump_target;
  logic            exc_valid, unsup_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cinsn_exec u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .insn_ready(insn_ready), .first_lo(first_lo), .len_two(len_two),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .wb_data(wb_data), .jump_valid(jump_valid), .jump_target(jump_target),
    .exc_valid(exc_valid), .unsup_valid(unsup_valid)
  );

  function automatic logic [15:0] enc(input int op, input int t, input int s, input int r);
    return {r[3:0], s[3:0], t[3:0], op[3:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // present one word for one edge, sample at the following falling edge
  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    insn_word  = w;
    insn_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  task automatic expect_wb(input string tag, input int idx, input logic [31:0] val);
    chk({tag, " wb_valid"}, 32'(wb_valid), 32'd1);
    chk({tag, " wb_idx"}, 32'(wb_idx), 32'(idx));
    chk({tag, " wb_data"}, wb_data, val);
  endtask

  // store register t out through the memory port and return its data
  task automatic read_reg(input int t, input int s, input int r,
                          output logic [31:0] data, output logic [31:0] addr);
    issue(enc(9, t, s, r));
    data = mem_req_wdata;
    addr = mem_req_addr;
    chk("R2 store req_valid", 32'(mem_req_valid), 32'd1);
    chk("R2 store write flag", 32'(mem_req_write), 32'd1);
    mem_req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R2 store no writeback", 32'(wb_valid), 32'd0);
    chk("R2 store done ready", 32'(insn_ready), 32'd1);
  endtask

  task automatic t_reset;
    chk("R13 wb_valid", 32'(wb_valid), 32'd0);
    chk("R13 jump_valid", 32'(jump_valid), 32'd0);
    chk("R13 exc_valid", 32'(exc_valid), 32'd0);
    chk("R13 unsup_valid", 32'(unsup_valid), 32'd0);
    chk("R13 mem_req_valid", 32'(mem_req_valid), 32'd0);
    chk("R13 insn_ready", 32'(insn_ready), 32'd1);
  endtask

  task automatic t_length;
    for (int i = 0; i < 16; i++) begin
      first_lo = 4'(i);
      #1;
      chk($sformatf("R1 len nibble %0d", i), 32'(len_two), 32'(i >= 8));
    end
  endtask

  task automatic t_movi;
    issue(enc(12, 2, 1, 5));  expect_wb("R6 pos", 1, 32'h25);
    issue(enc(12, 5, 2, 10)); expect_wb("R6 pos t5", 2, 32'h5A);
    issue(enc(12, 6, 4, 0));  expect_wb("R6 neg t6", 4, 32'hFFFFFFE0);
    issue(enc(12, 7, 10, 15)); expect_wb("R6 neg t7", 10, 32'hFFFFFFFF);
    issue(enc(12, 4, 11, 0)); expect_wb("R6 pos t4", 11, 32'h40);
    issue(enc(12, 3, 0, 0));  expect_wb("R6 r0", 0, 32'h30);
  endtask

  task automatic t_add;
    issue(enc(10, 2, 1, 3)); expect_wb("R4 add", 3, 32'h7F);
    issue(enc(10, 1, 4, 5)); expect_wb("R4 add neg", 5, 32'h5);
    issue(enc(10, 10, 10, 12)); expect_wb("R4 add self", 12, 32'hFFFFFFFE);
  endtask

  task automatic t_addi;
    issue(enc(11, 0, 1, 6));  expect_wb("R5 t0 minus one", 6, 32'h24);
    issue(enc(11, 15, 1, 7)); expect_wb("R5 t15", 7, 32'h34);
    issue(enc(11, 1, 10, 13)); expect_wb("R5 wrap", 13, 32'h0);
  endtask

  task automatic t_mov;
    logic [31:0] d, a;
    issue(enc(13, 8, 2, 0)); expect_wb("R7 mov", 8, 32'h5A);
    read_reg(8, 1, 3, d, a);
    chk("R7 mov readback", d, 32'h5A);
    chk("R2 store addr", a, 32'h31);
  endtask

  task automatic t_load;
    logic [31:0] d, a;
    issue(enc(8, 9, 2, 1));
    chk("R2 load req_valid", 32'(mem_req_valid), 32'd1);
    chk("R2 load write flag", 32'(mem_req_write), 32'd0);
    chk("R2 load addr", mem_req_addr, 32'h5E);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R12 held valid", 32'(mem_req_valid), 32'd1);
      chk("R12 held addr", mem_req_addr, 32'h5E);
      chk("R3 ready low", 32'(insn_ready), 32'd0);
    end
    mem_req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R3 req dropped", 32'(mem_req_valid), 32'd0);
    chk("R3 no wb before rsp", 32'(wb_valid), 32'd0);
    chk("R3 still busy", 32'(insn_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 waiting no wb", 32'(wb_valid), 32'd0);
    mem_rsp_valid = 1'b1;
    mem_rsp_rdata = 32'hDEADBEEF;
    @(posedge clk);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    expect_wb("R3 load", 9, 32'hDEADBEEF);
    chk("R3 ready again", 32'(insn_ready), 32'd1);
    read_reg(9, 0, 0, d, a);
    chk("R3 load readback", d, 32'hDEADBEEF);
  endtask

  task automatic t_ret;
    issue(enc(13, 0, 7, 15));
    chk("R8 jump_valid", 32'(jump_valid), 32'd1);
    chk("R8 jump_target", jump_target, 32'h30);
    chk("R8 no wb", 32'(wb_valid), 32'd0);
    @(negedge clk);
    chk("R8 one cycle", 32'(jump_valid), 32'd0);
  endtask

  task automatic t_nop;
    issue(enc(13, 3, 2, 15));
    chk("R9 nop outputs", 32'({wb_valid, jump_valid, exc_valid, unsup_valid}), 32'd0);
  endtask

  task automatic t_exc;
    logic [31:0] d, a;
    issue(enc(13, 6, 1, 15));
    chk("R10 ill exc", 32'(exc_valid), 32'd1);
    chk("R10 ill no wb", 32'(wb_valid), 32'd0);
    @(negedge clk);
    chk("R10 one cycle", 32'(exc_valid), 32'd0);
    issue(enc(13, 8, 1, 5));
    chk("R10 rsvd r5 exc", 32'(exc_valid), 32'd1);
    issue(enc(14, 8, 1, 0));
    chk("R10 op14 exc", 32'(exc_valid), 32'd1);
    issue(enc(3, 8, 1, 0));
    chk("R10 op3 exc", 32'(exc_valid), 32'd1);
    issue(enc(13, 9, 1, 15));
    chk("R10 rsvd t9 exc", 32'(exc_valid), 32'd1);
    read_reg(8, 0, 0, d, a);
    chk("R10 reg8 unchanged", d, 32'h5A);
  endtask

  task automatic t_unsup;
    logic [31:0] d, a;
    issue(enc(12, 9, 1, 0));
    chk("R11 branch unsup", 32'(unsup_valid), 32'd1);
    chk("R11 branch no wb", 32'(wb_valid), 32'd0);
    issue(enc(13, 1, 1, 15));
    chk("R11 wret unsup", 32'(unsup_valid), 32'd1);
    issue(enc(13, 2, 1, 15));
    chk("R11 break unsup", 32'(unsup_valid), 32'd1);
    @(negedge clk);
    chk("R11 one cycle", 32'(unsup_valid), 32'd0);
    read_reg(1, 0, 0, d, a);
    chk("R11 reg1 unchanged", d, 32'h25);
  endtask

  initial begin
    rst_n         = 1'b0;
    insn_valid    = 1'b0;
    insn_word     = '0;
    first_lo      = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_length();
    t_movi();
    t_add();
    t_addi();
    t_mov();
    t_load();
    t_ret();
    t_nop();
    t_exc();
    t_unsup();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule